// File: doc/BRIEF.md
# ISA Slave I/O Decode and DMA Request Front End

This block is the 8-bit ISA slave front end of a multi-function peripheral. It watches the system address, the address-enable line and the two active-low command strobes, and decides which of several I/O windows, if any, the host is touching. Each window has its own enable bit and a 16-byte aligned base. When a window is hit, the block issues a one-cycle register read or write strobe with the window and the register offset. It also controls when the data bus is driven and pulls the channel-ready line low while the addressed target is busy.

The block also generates the active-high 8-bit DMA request lines. Each request line stays asserted for a whole sample frame of 1, 2 or 4 bytes. The frame size follows that line's sample format. Each request line can be steered to any ISA DMA channel. The ISA inputs are assumed to be already synchronised to `clk`.

Top module: `isa_io_front`

## Requirements
- R1: While `aen` is 1, no window decodes, `sd_oe` and `iochrdy_low` stay 0, and no read or write strobe is issued, even when `sa` points into a window.
- R2: Window i matches when `win_en[i]` is 1 and `sa[11:4]` equals its base byte `win_base[8*i+7:8*i]`. A falling `ior_n` (or `iow_n`) during a match gives `rd_stb` (or `wr_stb`) high for exactly the one cycle after the clock edge that sees the fall. In that cycle `stb_win` holds the one-hot window and `reg_off` holds `sa[3:0]`.
- R3: `win_hit` is one-hot or zero. When enabled windows overlap, the lowest index wins. A disabled window never matches.
- R4: With `upper_dec_en` set to 1, a match also needs `sa[15:12]` to be 0. With it set to 0, `sa[15:12]` is ignored.
- R5: `sd_oe` is 1 only during a decoded read (`aen`=0, `ior_n`=0). It is 0 for writes.
- R6: For a window whose `win_periph` bit is 1, `sd_oe` is held at 0 while `sd_dis` or `serial_mode` is 1. Windows whose `win_periph` bit is 0 are not affected by these two inputs.
- R7: `iochrdy_low` is 1 while a decoded cycle is active and `tgt_ready` is 0. It returns to 0 as soon as `tgt_ready` is 1.
- R8: After 32 clock edges of stretching within one cycle, `iochrdy_low` is forced to 0 until the command strobe ends. The next cycle gets a fresh 32-edge allowance.
- R9: An idle request line that sees `dma_req` high asserts on the next clock edge. It is loaded with a byte count from its 2-bit `dma_fmt` field: bit0 means 16-bit and bit1 means stereo, so the count is 1, 2 or 4.
- R10: A line's count drops by one on each falling edge of `ior_n` or `iow_n` seen while the `dack_n` bit of its routed channel is 0. Strobes with any other DACK bit low are ignored. The line deasserts on the edge that takes its last byte.
- R11: After reset, lines 0, 1 and 2 route to channels 0, 1 and 3. A `route_we` pulse sets line `route_sel` to channel `route_wdata`. `drq_isa[c]` is the OR of all active lines routed to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa | input | 16 | System address |
| aen | input | 1 | High marks a DMA cycle, low marks an I/O cycle |
| ior_n | input | 1 | Active-low read command |
| iow_n | input | 1 | Active-low write command |
| upper_dec_en | input | 1 | Require sa[15:12] to be 0 for a match |
| win_base | input | 32 | Per-window base byte (address bits 11:4) |
| win_en | input | 4 | Per-window enable |
| win_periph | input | 4 | Marks windows that read from a peripheral |
| sd_dis | input | 1 | Configuration bit that blocks driving on peripheral reads |
| serial_mode | input | 1 | Shared data pins are in serial-port use |
| tgt_ready | input | 1 | Addressed target can complete the cycle |
| win_hit | output | 4 | One-hot decoded window |
| rd_stb | output | 1 | One-cycle register read strobe |
| wr_stb | output | 1 | One-cycle register write strobe |
| stb_win | output | 4 | Window captured with the strobe |
| reg_off | output | 4 | Register offset captured with the strobe |
| sd_oe | output | 1 | Data bus output enable |
| iochrdy_low | output | 1 | Pull the open-drain ready line low |
| dma_req | input | 3 | Per-line transfer request from the functional blocks |
| dma_fmt | input | 6 | Per-line sample format, 2 bits each |
| dack_n | input | 4 | Active-low DMA acknowledge per ISA channel |
| route_we | input | 1 | Load one routing entry |
| route_sel | input | 2 | Request line to reroute |
| route_wdata | input | 2 | New ISA channel for that line |
| drq_isa | output | 4 | DMA requests per ISA channel |

## Verification
An ISA DMA transfer byte and an I/O decode can fall on the same command edge. During a DMA cycle the host pulls `ior_n` low while `sa` can still hold a window address. The bench provokes this by running DACK-qualified byte strobes with `aen` high and `sa` aimed at window 0. It then judges two things on that same edge: the request line's byte count must drop and its request must eventually fall, while `rd_stb`, `sd_oe` and `iochrdy_low` must stay quiet.

// File: rtl/isa_front_pkg.sv
// Package: shared helpers for the ISA slave front end.
// Assumes the sample format is two bits: bit0 = 16-bit samples, bit1 = stereo.
package isa_front_pkg;

    localparam int FMT_W  = 2;
    localparam int BCNT_W = 3;

    // Bytes that make up one sample frame for a given format.
    function automatic logic [BCNT_W-1:0] frame_bytes(input logic [FMT_W-1:0] fmt);
        logic [BCNT_W-1:0] n;
        n = BCNT_W'(1);
        if (fmt[0]) n = n << 1;
        if (fmt[1]) n = n << 1;
        return n;
    endfunction

endpackage

// File: rtl/isa_win_decode.sv
// Module: isa_win_decode
// Compares the address against every enabled window base and resolves overlaps
// so that the lowest-numbered window wins. The decode is purely combinational.
// Assumes: bases are 16-byte aligned, so only address bits above 3 are compared.
// clk/rst_n serve the embedded assertions only.
module isa_win_decode #(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 16,
    parameter int LOW_W   = 12,
    localparam int BASE_W = LOW_W - 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:4]         sa_idx,
    input  logic                      aen,
    input  logic                      upper_dec_en,
    input  logic [NUM_WIN*BASE_W-1:0] win_base,
    input  logic [NUM_WIN-1:0]        win_en,
    output logic [NUM_WIN-1:0]        win_hit
);

    logic               upper_ok;
    logic [NUM_WIN-1:0] raw_match;

    // Upper bits must be zero only when alias suppression is on.
    assign upper_ok = !upper_dec_en || (sa_idx[ADDR_W-1:LOW_W] == '0);

    // Per-window comparator.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign raw_match[g] = win_en[g] && !aen && upper_ok &&
                              (sa_idx[LOW_W-1:4] == win_base[g*BASE_W +: BASE_W]);
    end

    // Fixed priority: lowest index overwrites last.
    always_comb begin
        win_hit = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (raw_match[i]) win_hit = NUM_WIN'(1) << i;
        end
    end

    p_aen_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> (win_hit == '0));
    p_one_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit));
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_dec_en && (win_hit != '0)) |-> (sa_idx[ADDR_W-1:LOW_W] == '0));

endmodule

// File: rtl/isa_cycle_ctrl.sv
// Module: isa_cycle_ctrl
// Turns decoded I/O cycles into one-cycle register strobes, drives the data
// bus enable with its suppression rules, and stretches cycles through the
// ready pull-down with a bounded wait. It also reports every command falling
// edge for the DMA byte counters.
// Assumes: ior_n/iow_n are synchronous to clk and idle high.
module isa_cycle_ctrl #(
    parameter int NUM_WIN = 4,
    parameter int TIMEOUT = 32,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aen,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic [3:0]         sa_off,
    input  logic [NUM_WIN-1:0] win_hit,
    input  logic [NUM_WIN-1:0] win_periph,
    input  logic               sd_dis,
    input  logic               serial_mode,
    input  logic               tgt_ready,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic [NUM_WIN-1:0] stb_win,
    output logic [3:0]         reg_off,
    output logic               sd_oe,
    output logic               iochrdy_low,
    output logic               cmd_fall
);

    logic             ior_q, iow_q;
    logic             any_hit, periph_hit;
    logic             rd_act, wr_act, io_act;
    logic             rd_fall, wr_fall;
    logic [CNT_W-1:0] wait_cnt;
    logic             timed_out;

    assign any_hit    = |win_hit;
    assign periph_hit = |(win_hit & win_periph);
    assign rd_act     = !aen && !ior_n && any_hit;
    assign wr_act     = !aen && !iow_n && any_hit;
    assign io_act     = rd_act || wr_act;
    assign rd_fall    = ior_q && !ior_n;
    assign wr_fall    = iow_q && !iow_n;
    assign cmd_fall   = rd_fall || wr_fall;

    // Remember last command levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ior_q <= 1'b1;
            iow_q <= 1'b1;
        end else begin
            ior_q <= ior_n;
            iow_q <= iow_n;
        end
    end

    // Emit one-cycle strobes with the captured window and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            stb_win <= '0;
            reg_off <= '0;
        end else begin
            rd_stb <= rd_fall && !aen && any_hit;
            wr_stb <= wr_fall && !aen && any_hit;
            if (cmd_fall && !aen && any_hit) begin
                stb_win <= win_hit;
                reg_off <= sa_off;
            end
        end
    end

    // Drive data only for reads that are not suppressed.
    assign sd_oe = rd_act && !(periph_hit && (sd_dis || serial_mode));

    // Count stretched edges within one cycle, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!io_act) begin
            wait_cnt <= '0;
        end else if (!tgt_ready && !timed_out) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign timed_out   = (wait_cnt == CNT_W'(TIMEOUT));
    assign iochrdy_low = io_act && !tgt_ready && !timed_out;

    p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));
    p_sd_only_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (!ior_n && !aen));
    p_no_drive_periph_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && periph_hit) |-> !(sd_dis || serial_mode));
    p_rdy_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iochrdy_low |-> (!aen && (!ior_n || !iow_n)));
    p_wait_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CNT_W'(TIMEOUT));
    p_timeout_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> !iochrdy_low);

endmodule

// File: rtl/isa_drq_line.sv
// Module: isa_drq_line
// One DMA request line. An idle line that sees its request loads the frame
// byte count; each acknowledged command edge takes one byte, and the request
// output stays up until the count is spent.
// Assumes: byte_evt is already qualified by the DACK of the routed channel.
module isa_drq_line
    import isa_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [FMT_W-1:0] fmt,
    input  logic             byte_evt,
    output logic             drq
);

    logic [BCNT_W-1:0] bytes_left;

    // Load a frame when idle, otherwise consume acknowledged bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_left <= '0;
        end else if (bytes_left == '0) begin
            if (req) bytes_left <= frame_bytes(fmt);
        end else if (byte_evt) begin
            bytes_left <= bytes_left - 1'b1;
        end
    end

    assign drq = (bytes_left != '0);

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_left <= BCNT_W'(4));
    p_rise_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(req));
    p_drop_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> $past(byte_evt));

endmodule

// File: rtl/isa_io_front.sv
// Module: isa_io_front (top)
// ISA 8-bit slave front end: window decode, register strobes, data drive
// control, ready stretching, and per-line DMA requests with channel routing.
// Assumes: all ISA inputs are synchronised to clk; reset is synchronous.
module isa_io_front
    import isa_front_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int ADDR_W   = 16,
    parameter int LOW_W    = 12,
    parameter int NUM_DRQ  = 3,
    parameter int NUM_CH   = 4,
    parameter int TIMEOUT  = 32,
    localparam int BASE_W  = LOW_W - 4,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int SEL_W   = $clog2(NUM_DRQ),
    parameter logic [NUM_DRQ*CH_W-1:0] DEF_ROUTE = {2'd3, 2'd1, 2'd0}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         sa,
    input  logic                      aen,
    input  logic                      ior_n,
    input  logic                      iow_n,
    input  logic                      upper_dec_en,
    input  logic [NUM_WIN*BASE_W-1:0] win_base,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN-1:0]        win_periph,
    input  logic                      sd_dis,
    input  logic                      serial_mode,
    input  logic                      tgt_ready,
    output logic [NUM_WIN-1:0]        win_hit,
    output logic                      rd_stb,
    output logic                      wr_stb,
    output logic [NUM_WIN-1:0]        stb_win,
    output logic [3:0]                reg_off,
    output logic                      sd_oe,
    output logic                      iochrdy_low,
    input  logic [NUM_DRQ-1:0]        dma_req,
    input  logic [NUM_DRQ*FMT_W-1:0]  dma_fmt,
    input  logic [NUM_CH-1:0]         dack_n,
    input  logic                      route_we,
    input  logic [SEL_W-1:0]          route_sel,
    input  logic [CH_W-1:0]           route_wdata,
    output logic [NUM_CH-1:0]         drq_isa
);

    logic              cmd_fall;
    logic [CH_W-1:0]   route_q [NUM_DRQ];
    logic [NUM_DRQ-1:0] line_drq;

    isa_win_decode #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .LOW_W   (LOW_W)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .sa_idx       (sa[ADDR_W-1:4]),
        .aen          (aen),
        .upper_dec_en (upper_dec_en),
        .win_base     (win_base),
        .win_en       (win_en),
        .win_hit      (win_hit)
    );

    isa_cycle_ctrl #(
        .NUM_WIN (NUM_WIN),
        .TIMEOUT (TIMEOUT)
    ) u_cyc (
        .clk         (clk),
        .rst_n       (rst_n),
        .aen         (aen),
        .ior_n       (ior_n),
        .iow_n       (iow_n),
        .sa_off      (sa[3:0]),
        .win_hit     (win_hit),
        .win_periph  (win_periph),
        .sd_dis      (sd_dis),
        .serial_mode (serial_mode),
        .tgt_ready   (tgt_ready),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .stb_win     (stb_win),
        .reg_off     (reg_off),
        .sd_oe       (sd_oe),
        .iochrdy_low (iochrdy_low),
        .cmd_fall    (cmd_fall)
    );

    // Routing table: default mapping at reset, one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DRQ; i++) route_q[i] <= DEF_ROUTE[i*CH_W +: CH_W];
        end else if (route_we) begin
            for (int i = 0; i < NUM_DRQ; i++) begin
                if (route_sel == SEL_W'(i)) route_q[i] <= route_wdata;
            end
        end
    end

    // One request line per functional DMA source.
    for (genvar g = 0; g < NUM_DRQ; g++) begin : g_line
        logic dack_sel_n;
        assign dack_sel_n = dack_n[route_q[g]];

        isa_drq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (dma_req[g]),
            .fmt      (dma_fmt[g*FMT_W +: FMT_W]),
            .byte_evt (cmd_fall && !dack_sel_n),
            .drq      (line_drq[g])
        );

        p_drq_routed_r11: assert property (@(posedge clk) disable iff (!rst_n)
            line_drq[g] |-> drq_isa[route_q[g]]);
    end

    // Merge active lines onto their routed channels.
    always_comb begin
        drq_isa = '0;
        for (int l = 0; l < NUM_DRQ; l++) begin
            drq_isa[route_q[l]] = drq_isa[route_q[l]] | line_drq[l];
        end
    end

endmodule

// File: tb/isa_io_front_tb.sv
module isa_io_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] sa;
    logic        aen, ior_n, iow_n, upper_dec_en;
    logic [31:0] win_base;
    logic [3:0]  win_en, win_periph;
    logic        sd_dis, serial_mode, tgt_ready;
    logic [3:0]  win_hit;
    logic        rd_stb, wr_stb;
    logic [3:0]  stb_win, reg_off;
    logic        sd_oe, iochrdy_low;
    logic [2:0]  dma_req;
    logic [5:0]  dma_fmt;
    logic [3:0]  dack_n;
    logic        route_we;
    logic [1:0]  route_sel, route_wdata;
    logic [3:0]  drq_isa;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    isa_io_front dut_i (
        .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
        .upper_dec_en(upper_dec_en), .win_base(win_base), .win_en(win_en),
        .win_periph(win_periph), .sd_dis(sd_dis), .serial_mode(serial_mode),
        .tgt_ready(tgt_ready), .win_hit(win_hit), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .stb_win(stb_win), .reg_off(reg_off), .sd_oe(sd_oe), .iochrdy_low(iochrdy_low),
        .dma_req(dma_req), .dma_fmt(dma_fmt), .dack_n(dack_n), .route_we(route_we),
        .route_sel(route_sel), .route_wdata(route_wdata), .drq_isa(drq_isa)
    );

    // {aen, upper_dec_en, sa, expected win_hit}
    localparam logic [21:0] VEC [10] = '{
        {1'b0, 1'b0, 16'h0225, 4'b0001},
        {1'b0, 1'b0, 16'h0384, 4'b0010},
        {1'b0, 1'b0, 16'h0530, 4'b1000},
        {1'b0, 1'b0, 16'h1225, 4'b0001},
        {1'b0, 1'b1, 16'h1225, 4'b0000},
        {1'b0, 1'b1, 16'h0225, 4'b0001},
        {1'b1, 1'b0, 16'h0225, 4'b0000},
        {1'b0, 1'b0, 16'h0240, 4'b0000},
        {1'b0, 1'b0, 16'h053F, 4'b1000},
        {1'b0, 1'b1, 16'hF384, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One DMA byte on channel ch with aen high and sa aimed at window 0.
    task automatic dma_byte(input bit rd, input int ch);
        aen = 1'b1;
        sa  = 16'h0225;
        dack_n[ch] = 1'b0;
        if (rd) ior_n = 1'b0; else iow_n = 1'b0;
        tick();
        chk("R1 no strobe during DMA", {30'd0, rd_stb, wr_stb}, 32'd0);
        chk("R1 no drive during DMA", {30'd0, sd_oe, iochrdy_low}, 32'd0);
        ior_n = 1'b1;
        iow_n = 1'b1;
        tick();
        dack_n = 4'hF;
        aen    = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sa = 16'h0; aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1;
        upper_dec_en = 1'b0; win_base = {8'h53, 8'h22, 8'h38, 8'h22};
        win_en = 4'hF; win_periph = 4'b1000; sd_dis = 1'b0; serial_mode = 1'b0;
        tgt_ready = 1'b1; dma_req = '0; dma_fmt = '0; dack_n = 4'hF;
        route_we = 1'b0; route_sel = '0; route_wdata = '0;
        repeat (3) tick();
        chk("R2 reset strobes", {30'd0, rd_stb, wr_stb}, 32'd0);
        chk("R7 reset ready", {31'd0, iochrdy_low}, 32'd0);
        chk("R9 reset drq", {28'd0, drq_isa}, 32'd0);
        rst_n = 1'b1;
        tick();

        // Decode table: R1 R3 R4
        for (int i = 0; i < 10; i++) begin
            aen          = VEC[i][21];
            upper_dec_en = VEC[i][20];
            sa           = VEC[i][19:4];
            #1;
            chk("R4/R1/R3 decode table", {28'd0, win_hit}, {28'd0, VEC[i][3:0]});
        end
        aen = 1'b0; upper_dec_en = 1'b0;
        tick();

        // R2/R5 read of window 0
        sa = 16'h0227; ior_n = 1'b0; #1;
        chk("R5 read drives", {31'd0, sd_oe}, 32'd1);
        tick();
        chk("R2 rd_stb", {31'd0, rd_stb}, 32'd1);
        chk("R2 reg_off", {28'd0, reg_off}, 32'd7);
        chk("R2 stb_win", {28'd0, stb_win}, 32'd1);
        tick();
        chk("R2 single pulse", {31'd0, rd_stb}, 32'd0);
        ior_n = 1'b1; tick();

        // R2/R5 write of window 1
        sa = 16'h038A; iow_n = 1'b0; #1;
        chk("R5 write no drive", {31'd0, sd_oe}, 32'd0);
        tick();
        chk("R2 wr_stb", {31'd0, wr_stb}, 32'd1);
        chk("R2 write offset", {28'd0, reg_off}, 32'hA);
        chk("R2 write window", {28'd0, stb_win}, 32'd2);
        iow_n = 1'b1; tick();

        // R6 data-drive suppression
        sa = 16'h0531; sd_dis = 1'b1; ior_n = 1'b0; #1;
        chk("R6 sd_dis blocks periph", {31'd0, sd_oe}, 32'd0);
        sd_dis = 1'b0; serial_mode = 1'b1; #1;
        chk("R6 serial blocks periph", {31'd0, sd_oe}, 32'd0);
        sa = 16'h0225; sd_dis = 1'b1; #1;
        chk("R6 non-periph still drives", {31'd0, sd_oe}, 32'd1);
        ior_n = 1'b1; sd_dis = 1'b0; serial_mode = 1'b0; tick();

        // R3 overlap with window 0 disabled
        win_en = 4'b1110; sa = 16'h0225; #1;
        chk("R3 next window takes over", {28'd0, win_hit}, 32'b0100);
        win_en = 4'hF; #1;
        chk("R3 lowest wins", {28'd0, win_hit}, 32'b0001);

        // R7 stretch and release
        tgt_ready = 1'b0; ior_n = 1'b0; #1;
        chk("R7 stretch", {31'd0, iochrdy_low}, 32'd1);
        repeat (3) tick();
        tgt_ready = 1'b1; #1;
        chk("R7 release on ready", {31'd0, iochrdy_low}, 32'd0);
        ior_n = 1'b1; tick();

        // R8 timeout
        tgt_ready = 1'b0; ior_n = 1'b0;
        repeat (31) tick();
        chk("R8 still low at 31", {31'd0, iochrdy_low}, 32'd1);
        tick();
        chk("R8 forced release at 32", {31'd0, iochrdy_low}, 32'd0);
        repeat (3) tick();
        chk("R8 stays released", {31'd0, iochrdy_low}, 32'd0);
        ior_n = 1'b1; tick();
        ior_n = 1'b0; #1;
        chk("R8 fresh allowance", {31'd0, iochrdy_low}, 32'd1);
        ior_n = 1'b1; tgt_ready = 1'b1; tick();

        // R1 aen high with window address and busy target
        tgt_ready = 1'b0; aen = 1'b1; ior_n = 1'b0; #1;
        chk("R1 no drive", {31'd0, sd_oe}, 32'd0);
        chk("R1 no stretch", {31'd0, iochrdy_low}, 32'd0);
        tick();
        chk("R1 no strobe", {31'd0, rd_stb}, 32'd0);
        ior_n = 1'b1; aen = 1'b0; tgt_ready = 1'b1; tick();

        // R9/R10 four-byte frame on line 0 (channel 0)
        dma_fmt = 6'b00_00_11; dma_req = 3'b001; tick();
        dma_req = '0;
        chk("R9 line0 asserts", {28'd0, drq_isa}, 32'b0001);
        for (int b = 0; b < 3; b++) dma_byte(1'b1, 0);
        chk("R10 held after 3 of 4", {28'd0, drq_isa}, 32'b0001);
        dma_byte(1'b1, 0);
        chk("R10 drops after 4", {28'd0, drq_isa}, 32'b0000);

        // R9 two-byte frame (16-bit mono)
        dma_fmt = 6'b00_00_01; dma_req = 3'b001; tick();
        dma_req = '0;
        dma_byte(1'b0, 0);
        chk("R9 16-bit held after 1", {28'd0, drq_isa}, 32'b0001);
        dma_byte(1'b0, 0);
        chk("R9 16-bit done after 2", {28'd0, drq_isa}, 32'b0000);

        // R9/R11 one-byte frame on line 1 (channel 1)
        dma_fmt = 6'b00_00_00; dma_req = 3'b010; tick();
        dma_req = '0;
        chk("R11 line1 on channel 1", {28'd0, drq_isa}, 32'b0010);
        dma_byte(1'b0, 1);
        chk("R9 8-bit mono one byte", {28'd0, drq_isa}, 32'b0000);

        // R10/R11 line 2 default channel 3, wrong DACK ignored, reroute
        dma_req = 3'b100; tick();
        dma_req = '0;
        chk("R11 line2 default channel 3", {28'd0, drq_isa}, 32'b1000);
        dma_byte(1'b1, 2);
        chk("R10 wrong DACK ignored", {28'd0, drq_isa}, 32'b1000);
        route_we = 1'b1; route_sel = 2'd2; route_wdata = 2'd2; tick();
        route_we = 1'b0;
        chk("R11 rerouted to channel 2", {28'd0, drq_isa}, 32'b0100);
        dma_byte(1'b1, 2);
        chk("R10 byte on new channel", {28'd0, drq_isa}, 32'b0000);

        done = 1;
        summary();
        $finish;
    end

endmodule